// File: doc/BRIEF.md
# Split-Readout Line Reassembler

This block rebuilds one full image line from a sensor that reads out through two outputs at once. The left output delivers its half of the line in natural column order. The right output delivers its half starting at the far right edge, so its pixels arrive mirrored. The block writes each right half into one of two alternating line banks. While it emits the left half of a line, the next right half can already be filling the other bank. After the last left pixel it reads the stored right half back from its highest address down, so the merged line comes out in sensor column order. The leading empty pixels of each half carry no charge, and the block drops them. Dark and photosensitive pixels are kept, even though the two halves hold different counts of each.

A mode input selects single or dual readout. In single readout the whole line comes from the left output and is forwarded untouched, including its empty pixels. In that mode the right input is refused. All three streams use valid/ready handshakes. A beat transfers on a rising clock edge where valid and ready are both high. A source that raises valid must hold valid and data until the beat is taken. The output may be stalled at any time by dropping `o_ready`. The stall propagates to the left input while the left half is being forwarded. The right input sees back-pressure only when both line banks hold halves that have not yet been emitted. The mode input and the line-length parameters are static while a line is in flight.

Top module: `lr_reassembly`

## Requirements
- R1: In single mode each accepted left beat appears on the output unchanged and in order. `o_sol` follows `l_sol`. `o_eol` is high on the beat at position SINGLE_LEN-1 of the line, where position 0 is the beat that carries `l_sol`.
- R2: In single mode `r_ready` stays low, and no right-stream pixel ever reaches the output.
- R3: In dual mode, left beats at positions 0 to EMPTY_LEN-1 of a half are accepted and discarded, with no output beat.
- R4: In dual mode, each merged line is 2*(HALF_LEN-EMPTY_LEN) beats long. It starts with the left-half pixels at positions EMPTY_LEN to HALF_LEN-1 in arrival order. It continues with the right-half pixels from position HALF_LEN-1 down to position EMPTY_LEN.
- R5: In dual mode `o_sol` is high only on the first beat of a merged line, and `o_eol` only on its last.
- R6: While `o_valid` is high and `o_ready` is low, `o_valid` and `o_data` hold their values into the next cycle.
- R7: In dual mode the right input accepts beats while at least one of the two banks is free. `r_ready` is low when both banks hold unread halves.
- R8: `o_err` goes high in the cycle after a right beat with `r_sol` is offered in dual mode while both banks are full. It then stays high until reset.
- R9: After reset `o_valid` and `o_err` are low, and in dual mode `r_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1: two-output readout, 0: left output only |
| l_valid | input | 1 | Left stream beat offered |
| l_ready | output | 1 | Left stream beat accepted |
| l_sol | input | 1 | Left beat is position 0 of its line |
| l_data | input | PIX_W | Left pixel value |
| r_valid | input | 1 | Right stream beat offered |
| r_ready | output | 1 | Right stream beat accepted |
| r_sol | input | 1 | Right beat is position 0 of its half |
| r_data | input | PIX_W | Right pixel value |
| o_valid | output | 1 | Output beat offered |
| o_ready | input | 1 | Downstream takes the output beat |
| o_sol | output | 1 | First beat of an output line |
| o_eol | output | 1 | Last beat of an output line |
| o_data | output | PIX_W | Output pixel value |
| o_err | output | 1 | Sticky flag: right half arrived with no bank free |

## Verification
Several line streams are driven with random valid gaps on both inputs and random output stalls. Every pixel value encodes its line, its side and its position, so a dropped, repeated, swapped or unreversed pixel shows up as a wrong value at a known output position. Single-mode lines are sent with the right input offering data all the time; this separates a clean pass-through from one that leaks right pixels or drops the empty pixels. Dual-mode lines let the right source run up to two halves ahead of the output, which exercises the ping-pong banks. A directed pass fills both banks while the output is stalled, then offers a third half. This checks the back-pressure limit and the sticky error, and it then drains both stored lines in order.

// File: rtl/lr_reassembly_pkg.sv
package lr_reassembly_pkg;
  // Which half of a dual-mode line the merge controller is emitting.
  typedef enum logic {
    PH_LEFT  = 1'b0,
    PH_RIGHT = 1'b1
  } lr_phase_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/lr_right_store.sv
module lr_right_store
  import lr_reassembly_pkg::*;
#(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned HALF_LEN = 2040,
  localparam int unsigned AW      = $clog2(HALF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_mode,
  input  logic             r_valid,
  output logic             r_ready,
  input  logic             r_sol,
  input  logic [PIX_W-1:0] r_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_done,
  output logic             bank_full,
  output logic [PIX_W-1:0] rd_data,
  output logic             err
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(HALF_LEN - 1);

  logic                 wr_bank_q, rd_bank_q;
  logic [AW-1:0]        wr_addr_q, waddr;
  logic [NUM_BANKS-1:0] full_q;
  logic [PIX_W-1:0]     bank_rd [NUM_BANKS];
  logic                 r_fire, half_end, err_q;

  assign waddr    = r_sol ? '0 : wr_addr_q;
  assign r_ready  = dual_mode && !full_q[wr_bank_q];
  assign r_fire   = r_valid && r_ready;
  assign half_end = r_fire && (waddr == LAST_ADDR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PIX_W-1:0] mem [HALF_LEN];

    always_ff @(posedge clk) begin
      if (r_fire && (wr_bank_q == 1'(b))) mem[waddr] <= r_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q[b] <= 1'b0;
      end else if (half_end && (wr_bank_q == 1'(b))) begin
        full_q[b] <= 1'b1;
      end else if (rd_done && (rd_bank_q == 1'(b))) begin
        full_q[b] <= 1'b0;
      end
    end

    assign bank_rd[b] = mem[rd_addr];

    // R7: a completed half always leaves its bank marked full
    a_r7_bank_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (half_end && (wr_bank_q == 1'(b))) |=> full_q[b]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank_q <= 1'b0;
      wr_addr_q <= '0;
      rd_bank_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (r_fire) begin
        if (half_end) begin
          wr_addr_q <= '0;
          wr_bank_q <= ~wr_bank_q;
        end else begin
          wr_addr_q <= waddr + 1'b1;
        end
      end
      if (rd_done) rd_bank_q <= ~rd_bank_q;
      if (dual_mode && r_valid && r_sol && (&full_q)) err_q <= 1'b1;
    end
  end

  assign bank_full = full_q[rd_bank_q];
  assign rd_data   = bank_rd[rd_bank_q];
  assign err       = err_q;

  // R8: once raised, the error flag holds until reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/lr_merge_ctrl.sv
module lr_merge_ctrl
  import lr_reassembly_pkg::*;
#(
  parameter int unsigned PIX_W      = 12,
  parameter int unsigned HALF_LEN   = 2040,
  parameter int unsigned EMPTY_LEN  = 4,
  parameter int unsigned SINGLE_LEN = 4076,
  localparam int unsigned AW        = $clog2(HALF_LEN),
  localparam int unsigned MAX_LEN   = (SINGLE_LEN > HALF_LEN) ? SINGLE_LEN : HALF_LEN,
  localparam int unsigned CW        = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_mode,
  input  logic             l_valid,
  output logic             l_ready,
  input  logic             l_sol,
  input  logic [PIX_W-1:0] l_data,
  input  logic             bank_full,
  input  logic [PIX_W-1:0] rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_done,
  output logic             o_valid,
  input  logic             o_ready,
  output logic             o_sol,
  output logic             o_eol,
  output logic [PIX_W-1:0] o_data
);
  localparam logic [CW-1:0] SINGLE_LAST = CW'(SINGLE_LEN - 1);
  localparam logic [CW-1:0] HALF_LAST   = CW'(HALF_LEN - 1);
  localparam logic [CW-1:0] FIRST_KEEP  = CW'(EMPTY_LEN);
  localparam logic [AW-1:0] RD_TOP      = AW'(HALF_LEN - 1);
  localparam logic [AW-1:0] RD_BOTTOM   = AW'(EMPTY_LEN);

  lr_phase_e     phase_q;
  logic [CW-1:0] idx_q, pos;
  logic [AW-1:0] rd_addr_q;
  logic          drop, l_fire;

  assign pos     = l_sol ? '0 : idx_q;
  assign l_fire  = l_valid && l_ready;
  assign rd_addr = rd_addr_q;

  always_comb begin
    drop    = 1'b0;
    l_ready = 1'b0;
    o_valid = 1'b0;
    o_sol   = 1'b0;
    o_eol   = 1'b0;
    o_data  = l_data;
    rd_done = 1'b0;
    if (!dual_mode) begin
      o_valid = l_valid;
      l_ready = o_ready;
      o_sol   = l_sol;
      o_eol   = (pos == SINGLE_LAST);
    end else if (phase_q == PH_LEFT) begin
      drop    = (pos < FIRST_KEEP);
      o_valid = l_valid && !drop;
      l_ready = drop || o_ready;
      o_sol   = (pos == FIRST_KEEP);
    end else begin
      o_valid = bank_full;
      o_data  = rd_data;
      o_eol   = (rd_addr_q == RD_BOTTOM);
      rd_done = bank_full && o_ready && (rd_addr_q == RD_BOTTOM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_LEFT;
      idx_q     <= '0;
      rd_addr_q <= '0;
    end else if (!dual_mode) begin
      phase_q <= PH_LEFT;
      if (l_fire) idx_q <= (pos == SINGLE_LAST) ? '0 : pos + 1'b1;
    end else if (phase_q == PH_LEFT) begin
      if (l_fire) begin
        if (pos == HALF_LAST) begin
          idx_q     <= '0;
          phase_q   <= PH_RIGHT;
          rd_addr_q <= RD_TOP;
        end else begin
          idx_q <= pos + 1'b1;
        end
      end
    end else if (bank_full && o_ready) begin
      if (rd_addr_q == RD_BOTTOM) phase_q <= PH_LEFT;
      else rd_addr_q <= rd_addr_q - 1'b1;
    end
  end

  // R6: a stalled output beat is held unchanged
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

  // R5: a merged line never starts and ends on the same beat
  a_r5_sol_eol_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && o_valid) |-> !(o_sol && o_eol));
endmodule

// File: rtl/lr_reassembly.sv
module lr_reassembly
  import lr_reassembly_pkg::*;
#(
  parameter int unsigned PIX_W      = 12,
  parameter int unsigned HALF_LEN   = 2040,
  parameter int unsigned EMPTY_LEN  = 4,
  parameter int unsigned SINGLE_LEN = 4076
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_mode,
  input  logic             l_valid,
  output logic             l_ready,
  input  logic             l_sol,
  input  logic [PIX_W-1:0] l_data,
  input  logic             r_valid,
  output logic             r_ready,
  input  logic             r_sol,
  input  logic [PIX_W-1:0] r_data,
  output logic             o_valid,
  input  logic             o_ready,
  output logic             o_sol,
  output logic             o_eol,
  output logic [PIX_W-1:0] o_data,
  output logic             o_err
);
  localparam int unsigned AW = $clog2(HALF_LEN);

  logic [AW-1:0]    rd_addr;
  logic             rd_done, bank_full;
  logic [PIX_W-1:0] rd_data;

  lr_right_store #(
    .PIX_W    (PIX_W),
    .HALF_LEN (HALF_LEN)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_mode (dual_mode),
    .r_valid   (r_valid),
    .r_ready   (r_ready),
    .r_sol     (r_sol),
    .r_data    (r_data),
    .rd_addr   (rd_addr),
    .rd_done   (rd_done),
    .bank_full (bank_full),
    .rd_data   (rd_data),
    .err       (o_err)
  );

  lr_merge_ctrl #(
    .PIX_W      (PIX_W),
    .HALF_LEN   (HALF_LEN),
    .EMPTY_LEN  (EMPTY_LEN),
    .SINGLE_LEN (SINGLE_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_mode (dual_mode),
    .l_valid   (l_valid),
    .l_ready   (l_ready),
    .l_sol     (l_sol),
    .l_data    (l_data),
    .bank_full (bank_full),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .rd_done   (rd_done),
    .o_valid   (o_valid),
    .o_ready   (o_ready),
    .o_sol     (o_sol),
    .o_eol     (o_eol),
    .o_data    (o_data)
  );

  // R2: the right input is never accepted in single mode
  a_r2_single_refuses_right: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> !r_ready);
endmodule

// File: tb/lr_reassembly_tb.sv
module lr_reassembly_tb;
  localparam int H  = 12;
  localparam int E  = 2;
  localparam int SL = 20;
  localparam int W  = 12;
  localparam int DL = 2 * (H - E);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_mode = 1'b0;
  logic l_valid = 1'b0, l_sol = 1'b0, r_valid = 1'b0, r_sol = 1'b0, o_ready = 1'b0;
  logic [W-1:0] l_data = '0, r_data = '0;
  logic l_ready, r_ready, o_valid, o_sol, o_eol, o_err;
  logic [W-1:0] o_data;

  int nchk = 0, nfail = 0;
  bit rdy_on = 1'b0, mon_on = 1'b0, chk_rblk = 1'b0, finished = 1'b0;
  int mon_line = 0, mon_pos = 0, r_sent = 0;
  bit prev_stall = 1'b0;
  logic [W-1:0] prev_data = '0;

  always #4 clk = ~clk;

  lr_reassembly #(.PIX_W(W), .HALF_LEN(H), .EMPTY_LEN(E), .SINGLE_LEN(SL)) u_dut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .l_valid(l_valid), .l_ready(l_ready), .l_sol(l_sol), .l_data(l_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_sol(r_sol), .r_data(r_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_sol(o_sol), .o_eol(o_eol),
    .o_data(o_data), .o_err(o_err)
  );

  function automatic logic [W-1:0] gen(int ln, bit side, int idx);
    return {4'(ln), side, 7'(idx)};
  endfunction

  function automatic logic [W-1:0] exp_pix(int ln, int pos, bit dual);
    if (!dual) return gen(ln, 1'b0, pos);
    if (pos < H - E) return gen(ln, 1'b0, E + pos);
    return gen(ln, 1'b1, H - 1 - (pos - (H - E)));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  // Output ready pattern
  initial forever begin
    @(posedge clk); #1;
    o_ready = rdy_on ? (($urandom % 4) != 0) : 1'b0;
  end

  // Output monitor
  initial forever begin
    @(negedge clk);
    if (mon_on) begin
      if (prev_stall)  // R6
        check(o_valid && (o_data == prev_data), "R6", "held beat", int'(o_data), int'(prev_data));
      if (chk_rblk)    // R2
        check(!r_ready, "R2", "r_ready in single mode", int'(r_ready), 0);
      if (o_valid && o_ready) begin
        int len;
        logic [W-1:0] ev;
        len = dual_mode ? DL : SL;
        ev  = exp_pix(mon_line, mon_pos, dual_mode);
        if (dual_mode) begin
          // R3 and R4: empties dropped, right half reversed after the left half
          check(o_data == ev, "R4", "merged pixel", int'(o_data), int'(ev));
          check((o_sol == (mon_pos == 0)) && (o_eol == (mon_pos == len - 1)), "R5",
                "sol/eol flags", int'({o_sol, o_eol}), int'({mon_pos == 0, mon_pos == len - 1}));
        end else begin
          check(o_data == ev, "R1", "pass-through pixel", int'(o_data), int'(ev));
          check((o_sol == (mon_pos == 0)) && (o_eol == (mon_pos == len - 1)), "R1",
                "sol/eol flags", int'({o_sol, o_eol}), int'({mon_pos == 0, mon_pos == len - 1}));
        end
        if (mon_pos == len - 1) begin
          mon_pos = 0;
          mon_line++;
        end else begin
          mon_pos++;
        end
      end
      prev_stall = o_valid && !o_ready;
      prev_data  = o_data;
    end
  end

  task automatic drive_left(int nlines, int len);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int i = 0; i < len; i++) begin
        bit acc;
        l_sol  = (i == 0);
        l_data = gen(ln, 1'b0, i);
        l_valid = 1'b0;
        do begin
          l_valid = l_valid || (($urandom % 4) != 0);
          @(negedge clk);
          acc = l_valid && l_ready;
          @(posedge clk); #1;
        end while (!acc);
        l_valid = 1'b0;
      end
    end
  endtask

  task automatic drive_right(int nlines, bit paced);
    for (int ln = 0; ln < nlines; ln++) begin
      while (paced && (r_sent - mon_line >= 2)) begin
        @(posedge clk); #1;
      end
      for (int i = 0; i < H; i++) begin
        bit acc;
        r_sol  = (i == 0);
        r_data = gen(ln, 1'b1, i);
        r_valid = 1'b0;
        do begin
          r_valid = r_valid || (($urandom % 4) != 0);
          @(negedge clk);
          acc = r_valid && r_ready;
          @(posedge clk); #1;
        end while (!acc);
        r_valid = 1'b0;
      end
      r_sent++;
    end
  endtask

  task automatic do_reset(bit dual);
    mon_on = 1'b0; rdy_on = 1'b0; chk_rblk = 1'b0;
    l_valid = 1'b0; r_valid = 1'b0;
    rst_n = 1'b0; dual_mode = dual;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_line = 0; mon_pos = 0; r_sent = 0; prev_stall = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R4", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));

    // R9: reset state, dual mode
    do_reset(1'b1);
    @(negedge clk);
    check(!o_valid, "R9", "o_valid after reset", int'(o_valid), 0);
    check(!o_err, "R9", "o_err after reset", int'(o_err), 0);
    check(r_ready, "R9", "r_ready after reset", int'(r_ready), 1);
    @(posedge clk); #1;

    // R1, R2: single mode, right input offering data throughout
    do_reset(1'b0);
    mon_on = 1'b1; rdy_on = 1'b1; chk_rblk = 1'b1;
    r_valid = 1'b1; r_sol = 1'b1; r_data = gen(9, 1'b1, 0);
    drive_left(3, SL);
    wait (mon_line == 3);
    r_valid = 1'b0;
    @(posedge clk); #1;

    // R3, R4, R5, R6, R7: dual mode with random gaps and stalls
    do_reset(1'b1);
    mon_on = 1'b1; rdy_on = 1'b1;
    fork
      drive_left(6, H);
      drive_right(6, 1'b1);
    join
    wait (mon_line == 6);
    @(negedge clk);
    check(!o_err, "R8", "no error in paced traffic", int'(o_err), 0);
    @(posedge clk); #1;

    // R7, R8: fill both banks while the output is stalled
    do_reset(1'b1);
    mon_on = 1'b1;
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < H; i++) begin
        r_valid = 1'b1; r_sol = (i == 0); r_data = gen(h, 1'b1, i);
        @(negedge clk);
        check(r_ready, "R7", "bank free accepts", int'(r_ready), 1);
        @(posedge clk); #1;
      end
    end
    r_valid = 1'b1; r_sol = 1'b1; r_data = gen(2, 1'b1, 0);
    @(negedge clk);
    check(!r_ready, "R7", "both banks full refuses", int'(r_ready), 0);
    check(!o_err, "R8", "error not yet raised", int'(o_err), 0);
    @(posedge clk); #1;
    r_valid = 1'b0;
    @(negedge clk);
    check(o_err, "R8", "error raised", int'(o_err), 1);
    @(posedge clk); #1;
    rdy_on = 1'b1;
    drive_left(2, H);
    wait (mon_line == 2);
    @(negedge clk);
    check(o_err, "R8", "error sticky", int'(o_err), 1);
    check(r_ready, "R7", "banks freed after drain", int'(r_ready), 1);
    @(posedge clk); #1;

    // R9: reset clears the error
    do_reset(1'b1);
    @(negedge clk);
    check(!o_err, "R9", "o_err cleared by reset", int'(o_err), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule